// File: doc/BRIEF.md
# Brightness, Contrast and Hue Adjust Unit

This block is a per-pixel correction stage placed in front of a plane's colour space converter. Each accepted pixel carries an unsigned 8-bit luma sample and two signed 8-bit chroma samples. Luma is first scaled by a contrast gain and then shifted by a signed brightness offset. The chroma pair is rotated and scaled by a programmable sine and cosine term, which gives hue and saturation control. Results come out saturated to their legal ranges a fixed two cycles after the input.

Software programs two 32-bit control words through a simple write port. The words land in a shadow copy, which is also what reads return. The shadow copy moves into the active set only on a vertical-blank pulse, so a setting can never change in the middle of a frame. One setting (contrast 75, brightness -19, sine 0, cosine 146) expands limited-range video to full range. The identity setting leaves pixels untouched.

Top module: `bcha_adjust`

## Requirements
- R1: After reset, word 0 reads 0x01000000 (contrast 64, brightness 0), word 1 reads 0x00000080 (sine 0, cosine 128), and outValid is low.
- R2: Word 0 (regAddr=0) holds contrast, unsigned with 6 fraction bits, in bits 26:18, and brightness, signed two's complement, in bits 7:0. Word 1 (regAddr=1) holds sine, signed with 7 fraction bits, in bits 26:16, and cosine, unsigned with 7 fraction bits, in bits 9:0. Other bits read as zero, and reads return the shadow word.
- R3: A register write has no effect on pixel results until a vblankPulse has been sampled.
- R4: A vblankPulse copies both shadow words into the active set, and pixels accepted in later cycles use the new values.
- R5: When a write and a vblankPulse are sampled in the same cycle, the active set takes the shadow value from before that write. The written value becomes active at the next pulse.
- R6: outValid is high exactly two cycles after each cycle in which pixValid was high, and low otherwise.
- R7: With the identity settings every pixel comes out unchanged, including the range extremes.
- R8: outY = sat0..255(((Y*contrast + 32) >> 6) + brightness). The contrast gain is applied before the brightness offset.
- R9: outCb = sat(-128..127)((cos*Cb + sin*Cr + 64) >>> 7) and outCr = sat(-128..127)((cos*Cr - sin*Cb + 64) >>> 7), using arithmetic shifts.
- R10: With contrast 75, brightness -19, sine 0 and cosine 146, luma 16 maps to 0, luma 235 maps to 255, and chroma +/-112 maps to 127/-128.
- R11: A pixel accepted in the same cycle as a vblankPulse is computed entirely with the settings that were active before the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the control words |
| regAddr | input | 1 | Selects control word 0 or 1 |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Shadow word selected by regAddr |
| vblankPulse | input | 1 | Copies shadow words into the active set |
| pixValid | input | 1 | Input pixel valid |
| pixY | input | 8 | Input luma, unsigned |
| pixCb | input | 8 | Input blue-difference chroma, signed |
| pixCr | input | 8 | Input red-difference chroma, signed |
| outValid | output | 1 | Output pixel valid |
| outY | output | 8 | Adjusted luma |
| outCb | output | 8 | Adjusted blue-difference chroma, signed |
| outCr | output | 8 | Adjusted red-difference chroma, signed |

## Verification
The identity setting is driven with extreme and mid-range samples, so any bias in rounding or sign handling shows up as a changed pixel. Contrast gains above and below one, together with a negative brightness, separate the order of gain and offset and exercise both saturation limits. A pure 90-degree rotation and a mixed sine/cosine pair show whether the sine term is applied with the right sign to each chroma output. The limited-range setting checks the full-range endpoints. Pixels sent next to writes and vblank pulses show whether a setting is applied late, early, or part-way through a pixel.

// File: rtl/bcha_pkg.sv
`timescale 1ns/1ps
package bcha_pkg;
  localparam int CON_W     = 9;
  localparam int CON_FRAC  = 6;
  localparam int CON_LSB   = 18;
  localparam int BRI_W     = 8;
  localparam int BRI_LSB   = 0;
  localparam int SIN_W     = 11;
  localparam int SIN_LSB   = 16;
  localparam int COS_W     = 10;
  localparam int COS_LSB   = 0;
  localparam int TRIG_FRAC = 7;
  localparam int WORD_W    = 32;

  localparam logic [WORD_W-1:0] W0_MASK =
    (((WORD_W'(1) << CON_W) - 1) << CON_LSB) | (((WORD_W'(1) << BRI_W) - 1) << BRI_LSB);
  localparam logic [WORD_W-1:0] W1_MASK =
    (((WORD_W'(1) << SIN_W) - 1) << SIN_LSB) | (((WORD_W'(1) << COS_W) - 1) << COS_LSB);
  localparam logic [WORD_W-1:0] W0_RESET = WORD_W'(1) << (CON_FRAC + CON_LSB);
  localparam logic [WORD_W-1:0] W1_RESET = WORD_W'(1) << (TRIG_FRAC + COS_LSB);

  typedef struct packed {
    logic [CON_W-1:0]        contrast;
    logic signed [BRI_W-1:0] bright;
    logic signed [SIN_W-1:0] sinT;
    logic [COS_W-1:0]        cosT;
  } adjCtrl_t;
endpackage

// File: rtl/bcha_regs.sv
`timescale 1ns/1ps
module bcha_regs
  import bcha_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              vblankPulse,
  output adjCtrl_t          ctrl
);
  logic [WORD_W-1:0] shadow0, shadow1, active0, active1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow0 <= W0_RESET;
      shadow1 <= W1_RESET;
      active0 <= W0_RESET;
      active1 <= W1_RESET;
    end else begin
      if (vblankPulse) begin
        active0 <= shadow0;
        active1 <= shadow1;
      end
      if (regWrEn) begin
        if (regAddr) shadow1 <= regWrData & W1_MASK;
        else         shadow0 <= regWrData & W0_MASK;
      end
    end
  end

  assign regRdData = regAddr ? shadow1 : shadow0;

  always_comb begin
    ctrl.contrast = active0[CON_LSB +: CON_W];
    ctrl.bright   = active0[BRI_LSB +: BRI_W];
    ctrl.sinT     = active1[SIN_LSB +: SIN_W];
    ctrl.cosT     = active1[COS_LSB +: COS_W];
  end

  // R3: without a pulse the active set holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !vblankPulse |=> ($stable(active0) && $stable(active1)));
  // R4, R5: a pulse loads the shadow as it stood before any same-cycle write
  p_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    vblankPulse |=> (active0 == $past(shadow0) && active1 == $past(shadow1)));
  // R2: a write to word 0 is stored with only its defined fields
  p_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regAddr) |=> (regRdData == ($past(regWrData) & W0_MASK)) || regAddr);
endmodule

// File: rtl/bcha_datapath.sv
`timescale 1ns/1ps
module bcha_datapath
  import bcha_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  adjCtrl_t         ctrl,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixY,
  input  logic [PIX_W-1:0] pixCb,
  input  logic [PIX_W-1:0] pixCr,
  output logic             outValid,
  output logic [PIX_W-1:0] outY,
  output logic [PIX_W-1:0] outCb,
  output logic [PIX_W-1:0] outCr
);
  localparam int PROD_W = PIX_W + CON_W;
  localparam int LUM_W  = PROD_W - CON_FRAC + 1;
  localparam int SUM_W  = PIX_W + SIN_W + 3;
  localparam int SH_W   = SUM_W - TRIG_FRAC;
  localparam int LSUM_W = LUM_W + 2;
  localparam logic [PROD_W-1:0]       Y_RND = PROD_W'(1) << (CON_FRAC - 1);
  localparam logic signed [SUM_W-1:0] C_RND = SUM_W'(1) << (TRIG_FRAC - 1);
  localparam int Y_MAX = (1 << PIX_W) - 1;
  localparam int C_MAX = (1 << (PIX_W - 1)) - 1;
  localparam int C_MIN = -(1 << (PIX_W - 1));

  // stage 1: products, with brightness carried along
  logic                    s1Valid;
  logic [PROD_W-1:0]       s1YProd;
  logic signed [SUM_W-1:0] s1CbSum, s1CrSum;
  logic signed [BRI_W-1:0] s1Bri;
  logic signed [COS_W:0]   cosS;
  logic signed [PIX_W-1:0] cbIn, crIn;

  assign cosS = $signed({1'b0, ctrl.cosT});
  assign cbIn = $signed(pixCb);
  assign crIn = $signed(pixCr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1YProd <= '0;
      s1CbSum <= '0;
      s1CrSum <= '0;
      s1Bri   <= '0;
    end else begin
      s1Valid <= pixValid;
      if (pixValid) begin
        s1YProd <= PROD_W'(pixY) * PROD_W'(ctrl.contrast);
        s1CbSum <= SUM_W'(cosS) * SUM_W'(cbIn) + SUM_W'(ctrl.sinT) * SUM_W'(crIn);
        s1CrSum <= SUM_W'(cosS) * SUM_W'(crIn) - SUM_W'(ctrl.sinT) * SUM_W'(cbIn);
        s1Bri   <= ctrl.bright;
      end
    end
  end

  // stage 2: round, offset, saturate
  logic [PROD_W-1:0]        yRnd;
  logic signed [LSUM_W-1:0] lumSum;
  logic signed [SUM_W-1:0]  cbRnd, crRnd;
  logic signed [SH_W-1:0]   cbSh, crSh;
  logic [PIX_W-1:0]         yNext, cbNext, crNext;

  function automatic logic [PIX_W-1:0] satChroma(input logic signed [SH_W-1:0] v);
    if (v > SH_W'(C_MAX))      return PIX_W'(C_MAX);
    else if (v < SH_W'(C_MIN)) return PIX_W'(C_MIN);
    else                       return v[PIX_W-1:0];
  endfunction

  always_comb begin
    yRnd   = s1YProd + Y_RND;
    lumSum = $signed(LSUM_W'(yRnd >> CON_FRAC)) + LSUM_W'(s1Bri);
    if (lumSum < 0)                    yNext = '0;
    else if (lumSum > LSUM_W'(Y_MAX))  yNext = PIX_W'(Y_MAX);
    else                               yNext = lumSum[PIX_W-1:0];
    cbRnd  = s1CbSum + C_RND;
    crRnd  = s1CrSum + C_RND;
    cbSh   = SH_W'(cbRnd >>> TRIG_FRAC);
    crSh   = SH_W'(crRnd >>> TRIG_FRAC);
    cbNext = satChroma(cbSh);
    crNext = satChroma(crSh);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outY     <= '0;
      outCb    <= '0;
      outCr    <= '0;
    end else begin
      outValid <= s1Valid;
      if (s1Valid) begin
        outY  <= yNext;
        outCb <= cbNext;
        outCr <= crNext;
      end
    end
  end

  // cycles since reset, so the latency check never looks before reset
  logic [1:0] warmCnt;
  always_ff @(posedge clk) begin
    if (!rstN)              warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  // R6: output valid two cycles after input valid
  p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt >= 2'd2) |-> (outValid == $past(pixValid, 2)));
endmodule

// File: rtl/bcha_adjust.sv
`timescale 1ns/1ps
module bcha_adjust
  import bcha_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  logic              vblankPulse,
  input  logic              pixValid,
  input  logic [PIX_W-1:0]  pixY,
  input  logic [PIX_W-1:0]  pixCb,
  input  logic [PIX_W-1:0]  pixCr,
  output logic              outValid,
  output logic [PIX_W-1:0]  outY,
  output logic [PIX_W-1:0]  outCb,
  output logic [PIX_W-1:0]  outCr
);
  adjCtrl_t ctrl;

  bcha_regs uRegs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .vblankPulse(vblankPulse), .ctrl(ctrl)
  );

  bcha_datapath #(.PIX_W(PIX_W)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .pixValid(pixValid),
    .pixY(pixY), .pixCb(pixCb), .pixCr(pixCr),
    .outValid(outValid), .outY(outY), .outCb(outCb), .outCr(outCr)
  );
endmodule

// File: tb/tb_bcha_adjust.sv
`timescale 1ns/1ps
module tb_bcha_adjust;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regAddr = 1'b0, vblankPulse = 1'b0, pixValid = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [7:0] pixY = '0, pixCb = '0, pixCr = '0;
  logic outValid;
  logic [7:0] outY, outCb, outCr;

  bcha_adjust dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .vblankPulse(vblankPulse),
    .pixValid(pixValid), .pixY(pixY), .pixCb(pixCb), .pixCr(pixCr),
    .outValid(outValid), .outY(outY), .outCb(outCb), .outCr(outCr)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycleCnt = 0;
  bit done = 1'b0;
  logic [31:0] sh0 = 32'h0100_0000, sh1 = 32'h0000_0080;
  logic [31:0] ac0 = 32'h0100_0000, ac1 = 32'h0000_0080;
  logic [23:0] expQ[$];
  int cycQ[$];
  string tagQ[$];

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  function automatic logic [31:0] mkW0(int con, int bri);
    return (32'(con) << 18) | (32'(bri) & 32'hFF);
  endfunction
  function automatic logic [31:0] mkW1(int sn, int cs);
    return ((32'(sn) & 32'h7FF) << 16) | 32'(cs);
  endfunction
  function automatic int clampI(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction
  function automatic logic [23:0] model(int y, int cb, int cr, logic [31:0] a0, logic [31:0] a1);
    int con = int'(a0[26:18]);
    int bri = int'($signed(a0[7:0]));
    int sn  = int'($signed(a1[26:16]));
    int cs  = int'(a1[9:0]);
    int yo  = clampI(((y * con + 32) >>> 6) + bri, 0, 255);
    int cbo = clampI((cs * cb + sn * cr + 64) >>> 7, -128, 127);
    int cro = clampI((cs * cr - sn * cb + 64) >>> 7, -128, 127);
    return {yo[7:0], cbo[7:0], cro[7:0]};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idleAll();
    pixValid = 1'b0; vblankPulse = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); idleAll();
    end
  endtask

  task automatic pushPix(int y, int cb, int cr, string tag);
    pixValid = 1'b1; pixY = 8'(y); pixCb = 8'(cb); pixCr = 8'(cr);
    expQ.push_back(model(y, cb, cr, ac0, ac1));
    cycQ.push_back(cycleCnt + 2);
    tagQ.push_back(tag);
  endtask

  task automatic sendPix(int y, int cb, int cr, string tag);
    @(negedge clk); idleAll();
    pushPix(y, cb, cr, tag);
  endtask

  task automatic writeReg(bit addr, logic [31:0] data, bit withLoad);
    @(negedge clk); idleAll();
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    if (withLoad) begin
      vblankPulse = 1'b1; ac0 = sh0; ac1 = sh1;
    end
    if (addr) sh1 = data & 32'h07FF_03FF; else sh0 = data & 32'h07FC_00FF;
  endtask

  task automatic vblank();
    @(negedge clk); idleAll();
    vblankPulse = 1'b1; ac0 = sh0; ac1 = sh1;
  endtask

  task automatic checkRead(bit addr, logic [31:0] exp, string tag);
    @(negedge clk); idleAll();
    regAddr = addr;
    #1;
    check(regRdData === exp, tag, regRdData, exp);
  endtask

  // monitor: compare each produced pixel with the scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        if (expQ.size() == 0) check(1'b0, "R6 unexpected outValid", 32'd1, 32'd0);
        else begin
          logic [23:0] e;
          int c;
          string t;
          e = expQ.pop_front(); c = cycQ.pop_front(); t = tagQ.pop_front();
          check(c == cycleCnt, {t, " R6 latency"}, 32'(cycleCnt), 32'(c));
          check({outY, outCb, outCr} === e, t, {8'h0, outY, outCb, outCr}, {8'h0, e});
        end
      end else if (cycQ.size() != 0 && cycQ[0] < cycleCnt) begin
        check(1'b0, {tagQ[0], " R6 missing output"}, 32'd0, 32'd1);
        void'(expQ.pop_front()); void'(cycQ.pop_front()); void'(tagQ.pop_front());
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check(outValid === 1'b0, "R1 outValid after reset", 32'(outValid), 32'd0);
    checkRead(1'b0, 32'h0100_0000, "R1 word0 reset");
    checkRead(1'b1, 32'h0000_0080, "R1 word1 reset");

    // R7 identity
    sendPix(0, -128, 127, "R7 identity low");
    sendPix(255, 127, -128, "R7 identity high");
    sendPix(100, -5, 33, "R7 identity mid");
    sendPix(1, 0, -1, "R7 identity small");
    idle(3);

    // R2 field layout and masking
    writeReg(1'b0, 32'hFFFF_FFFF, 1'b0);
    checkRead(1'b0, 32'h07FC_00FF, "R2 word0 mask");
    writeReg(1'b1, 32'hFFFF_FFFF, 1'b0);
    checkRead(1'b1, 32'h07FF_03FF, "R2 word1 mask");
    writeReg(1'b0, mkW0(128, 0), 1'b0);
    writeReg(1'b1, mkW1(0, 128), 1'b0);
    checkRead(1'b0, 32'h0200_0000, "R2 word0 contrast field");

    // R3 shadow not yet active
    sendPix(200, 10, -10, "R3 write pending");
    sendPix(50, 0, 0, "R3 write pending 2");
    idle(3);
    // R4 load, R8 gain with saturation
    vblank();
    sendPix(200, 10, -10, "R4 R8 gain 2 saturates");
    sendPix(50, 0, 0, "R4 R8 gain 2");
    idle(3);

    // R8 rounding and order: contrast before brightness
    writeReg(1'b0, mkW0(96, -100), 1'b0);
    vblank();
    sendPix(1, 0, 0, "R8 round low clamp");
    sendPix(200, 0, 0, "R8 gain then offset");
    sendPix(255, 0, 0, "R8 top");
    writeReg(1'b0, mkW0(40, 20), 1'b0);
    vblank();
    sendPix(3, 0, 0, "R8 gain below one");
    sendPix(250, 0, 0, "R8 gain below one high");
    idle(3);

    // R9 rotation by 90 degrees and mixed terms
    writeReg(1'b0, mkW0(64, 0), 1'b0);
    writeReg(1'b1, mkW1(128, 0), 1'b0);
    vblank();
    sendPix(80, -128, 50, "R9 rotate sat");
    sendPix(80, 40, -30, "R9 rotate");
    writeReg(1'b1, mkW1(-64, 111), 1'b0);
    vblank();
    sendPix(80, 100, -90, "R9 mixed");
    sendPix(80, -77, 13, "R9 mixed 2");
    sendPix(80, 127, 127, "R9 mixed 3");
    writeReg(1'b1, mkW1(-1024, 1023), 1'b0);
    vblank();
    sendPix(80, 127, -128, "R9 extremes");
    sendPix(80, -128, 127, "R9 extremes 2");
    idle(3);

    // R10 limited to full range expansion
    writeReg(1'b0, mkW0(75, -19), 1'b0);
    writeReg(1'b1, mkW1(0, 146), 1'b0);
    vblank();
    pixValid = 1'b0;
    @(negedge clk); idleAll();
    pixValid = 1'b1; pixY = 8'd16; pixCb = 8'd112; pixCr = 8'(-112);
    expQ.push_back({8'd0, 8'd127, 8'h80}); cycQ.push_back(cycleCnt + 2); tagQ.push_back("R10 black and chroma ends");
    @(negedge clk); idleAll();
    pixValid = 1'b1; pixY = 8'd235; pixCb = 8'd0; pixCr = 8'd0;
    expQ.push_back({8'd255, 8'd0, 8'd0}); cycQ.push_back(cycleCnt + 2); tagQ.push_back("R10 white");
    sendPix(126, 56, -56, "R10 mid");
    idle(3);

    // R5 write and load in the same cycle
    writeReg(1'b0, mkW0(32, 0), 1'b1);
    sendPix(100, 0, 0, "R5 old shadow loaded");
    vblank();
    sendPix(100, 0, 0, "R5 new value after next load");
    idle(3);

    // R11 pixel accepted with a load
    writeReg(1'b0, mkW0(64, 50), 1'b0);
    @(negedge clk); idleAll();
    pushPix(100, 20, 20, "R11 pixel with load");
    vblankPulse = 1'b1; ac0 = sh0; ac1 = sh1;
    sendPix(100, 20, 20, "R11 pixel after load");
    idle(4);

    check(expQ.size() == 0, "R6 all outputs seen", 32'(expQ.size()), 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule